// File: doc/BRIEF.md
# Transfer Command Descriptor Encoder

This block turns one transfer request into a 64-bit command descriptor for the command queue of an I3C host controller. Each request carries a direction, a byte count, up to four payload bytes, a device table index, an optional common-command code with a broadcast flag, the bus type (I3C or I2C) and the configured clock rate in hertz. The block picks the descriptor shape and derives the speed-mode code from the rate through fixed thresholds. It stamps a 4-bit transaction ID from a rolling counter and holds the finished descriptor in an output register.

A short write of at most four bytes goes out in the immediate shape, with the payload packed into the high word. Every read, and every longer write, goes out in the regular shape, which carries a 16-bit length and leaves the data to a separate buffer. The producer pulses `reqStart` while `startReady` is high. The consumer takes the two words with a valid/ready handshake. The transaction ID counter advances once for each descriptor the consumer accepts.

Top module: `desc_encoder`

## Requirements
- R1: Word-0 bits 2:0 hold the shape code: 1 (immediate) when the request is a write of 0 to 4 bytes, and 0 (regular) for any read or any write longer than 4 bytes.
- R2: In the immediate shape, word-0 bits 25:23 hold the byte count and word-0 bit 29 is 0. Payload byte k (k = 0..3, taken from `reqPayload[8k+7:8k]`) sits in word-1 bits 8k+7:8k when k is below the count, and every lane at or above the count is zero.
- R3: In the regular shape, word-1 bits 31:16 hold the 16-bit length, word-1 bits 15:0 are zero, word-0 bit 29 is the read flag, and word-0 bits 25:23 are zero.
- R4: In both shapes the transaction ID sits in word-0 bits 6:3 and the device index in word-0 bits 20:16.
- R5: With a common command present, its 8-bit code sits in word-0 bits 14:7 and bit 15 is set. Without one, bits 15:7 are zero. A broadcast common command forces the device index field to 0.
- R6: For I3C requests, word-0 bits 28:26 hold 0 for a rate above 8 MHz, 1 above 6 MHz, 2 above 4 MHz, 3 above 2 MHz, and 4 otherwise. A rate equal to a threshold falls into the slower code.
- R7: For I2C requests, word-0 bits 28:26 hold 1 when the rate is at least 1 MHz and 0 otherwise.
- R8: The transaction ID is 0 for the first descriptor after reset. It advances by one for each descriptor accepted by the consumer (`descValid` and `descReady` high together) and wraps from 15 to 0.
- R9: Word-0 bits 31:30 and 22:21 are always zero.
- R10: A request is taken only when `startReady` is high, which is exactly when `descValid` is low. Its descriptor appears with `descValid` one cycle later. While `descValid` is high and `descReady` is low, both words stay unchanged and `reqStart` has no effect.
- R11: During and right after reset, `descValid` is low and `startReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Request strobe, taken when `startReady` is high |
| startReady | output | 1 | Output register empty, a request can be taken |
| reqRead | input | 1 | 1 for a read transfer |
| reqLen | input | 16 | Transfer length in bytes |
| reqPayload | input | 32 | Up to four write bytes, byte 0 in bits 7:0 |
| reqDevIdx | input | 5 | Device table index |
| reqCccValid | input | 1 | A common command is attached |
| reqCccCode | input | 8 | Common-command code |
| reqCccBcast | input | 1 | The common command is a broadcast |
| reqBusI2c | input | 1 | 1 for an I2C target, 0 for I3C |
| reqRateHz | input | RATE_W (32) | Configured bus clock rate in hertz |
| descValid | output | 1 | Descriptor held and offered |
| descReady | input | 1 | Consumer takes the descriptor |
| descWord0 | output | 32 | Descriptor word 0 |
| descWord1 | output | 32 | Descriptor word 1 |

## Verification
The bench goes after the rate thresholds at their exact values and one hertz above them. A comparison with the wrong sense would put a rate of exactly 8, 6, 4 or 2 MHz (or 1 MHz for I2C) into the wrong code. It sweeps lengths 0 to 5 in both directions, which catches a shape chosen on the wrong side of four bytes and stale payload bytes left in unused lanes. It runs well past sixteen accepted descriptors under random consumer stalls, which exposes a transaction ID that advances on load instead of on acceptance, or that fails to wrap. It also catches an output register that reloads or shifts while stalled. Broadcast common commands with nonzero indices expose an index that is not forced to zero.

// File: rtl/desc_enc_pkg.sv
package desc_enc_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int IDX_W  = 5;
  localparam int TID_W  = 4;
  localparam int CODE_W = 8;
  localparam int MODE_W = 3;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int CNT_W  = 3;

  // word-0 field positions (decoded by the queue consumer)
  localparam int POS_FMT  = 0;
  localparam int POS_TID  = 3;
  localparam int POS_CODE = 7;
  localparam int POS_CP   = 15;
  localparam int POS_IDX  = 16;
  localparam int POS_CNT  = 23;
  localparam int POS_MODE = 26;
  localparam int POS_RD   = 29;
  // word-1 field position for the regular length
  localparam int POS_LEN  = 16;

  typedef enum logic [2:0] {
    FMT_REGULAR   = 3'd0,
    FMT_IMMEDIATE = 3'd1
  } fmtE;

  typedef struct packed {
    logic load;     // capture a new descriptor
    logic advance;  // consumer took the held descriptor
  } strobeT;
endpackage

// File: rtl/desc_enc_ctrl.sv
module desc_enc_ctrl
  import desc_enc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   reqStart,
  input  logic   descReady,
  output logic   startReady,
  output logic   descValid,
  output strobeT strobes
);
  typedef enum logic {ST_EMPTY = 1'b0, ST_FULL = 1'b1} stateE;
  stateE stateQ, stateD;

  always_comb begin
    strobes.load    = (stateQ == ST_EMPTY) && reqStart;
    strobes.advance = (stateQ == ST_FULL) && descReady;
    stateD = stateQ;
    if (strobes.load)    stateD = ST_FULL;
    if (strobes.advance) stateD = ST_EMPTY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_EMPTY;
    else        stateQ <= stateD;
  end

  assign descValid  = (stateQ == ST_FULL);
  assign startReady = (stateQ == ST_EMPTY);

  // R10: a load is followed by an offered descriptor
  p_load_then_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> descValid);
  // R10: an unaccepted descriptor stays offered
  p_stall_keeps_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && !descReady |=> descValid);
endmodule

// File: rtl/desc_enc_datapath.sv
module desc_enc_datapath
  import desc_enc_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter logic [RATE_W-1:0] I3C_STEP [4] = '{32'd8000000, 32'd6000000, 32'd4000000, 32'd2000000},
  parameter logic [RATE_W-1:0] I2C_FAST_HZ = 32'd1000000
)(
  input  logic                clk,
  input  logic                rst_n,
  input  strobeT              strobes,
  input  logic                reqRead,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic [WORD_W-1:0]   reqPayload,
  input  logic [IDX_W-1:0]    reqDevIdx,
  input  logic                reqCccValid,
  input  logic [CODE_W-1:0]   reqCccCode,
  input  logic                reqCccBcast,
  input  logic                reqBusI2c,
  input  logic [RATE_W-1:0]   reqRateHz,
  output logic [WORD_W-1:0]   descWord0,
  output logic [WORD_W-1:0]   descWord1
);
  localparam int STEPS = 4;

  logic                isImm;
  logic [STEPS-1:0]    notAbove;
  logic [MODE_W-1:0]   i3cMode, modeCode;
  logic [WORD_W-1:0]   immData, nextW0, nextW1;
  logic [WORD_W-1:0]   w0Q, w1Q;
  logic [TID_W-1:0]    tidQ;
  logic [IDX_W-1:0]    idxEff;

  assign isImm = !reqRead && (reqLen <= LEN_W'(LANES));

  // one comparator per rate step; slower codes count more steps not exceeded
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign notAbove[g] = (reqRateHz <= I3C_STEP[g]);
  end

  always_comb begin
    i3cMode = '0;
    for (int k = 0; k < STEPS; k++) i3cMode = i3cMode + MODE_W'(notAbove[k]);
  end

  assign modeCode = reqBusI2c ? ((reqRateHz >= I2C_FAST_HZ) ? MODE_W'(1) : MODE_W'(0))
                              : i3cMode;

  // payload lanes beyond the byte count are cleared
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign immData[g*LANE_W +: LANE_W] =
      (reqLen > LEN_W'(g)) ? reqPayload[g*LANE_W +: LANE_W] : '0;
  end

  assign idxEff = (reqCccValid && reqCccBcast) ? '0 : reqDevIdx;

  always_comb begin
    nextW0 = '0;
    nextW0[POS_FMT  +: 3]      = isImm ? FMT_IMMEDIATE : FMT_REGULAR;
    nextW0[POS_TID  +: TID_W]  = tidQ;
    nextW0[POS_IDX  +: IDX_W]  = idxEff;
    nextW0[POS_MODE +: MODE_W] = modeCode;
    if (reqCccValid) begin
      nextW0[POS_CODE +: CODE_W] = reqCccCode;
      nextW0[POS_CP]             = 1'b1;
    end
    if (isImm) nextW0[POS_CNT +: CNT_W] = reqLen[CNT_W-1:0];
    else       nextW0[POS_RD]           = reqRead;
  end

  always_comb begin
    nextW1 = '0;
    if (isImm) nextW1 = immData;
    else       nextW1[POS_LEN +: LEN_W] = reqLen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0Q  <= '0;
      w1Q  <= '0;
      tidQ <= '0;
    end else begin
      if (strobes.load) begin
        w0Q <= nextW0;
        w1Q <= nextW1;
      end
      if (strobes.advance) tidQ <= tidQ + 1'b1;
    end
  end

  assign descWord0 = w0Q;
  assign descWord1 = w1Q;

  // R8: the ID counter moves by exactly one per accepted descriptor
  p_tid_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.advance |=> tidQ == $past(tidQ) + 1'b1);
  p_tid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.advance |=> $stable(tidQ));
  // R10: held words change only on a load
  p_words_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> $stable(w0Q) && $stable(w1Q));
endmodule

// File: rtl/desc_encoder.sv
module desc_encoder
  import desc_enc_pkg::*;
#(
  parameter int RATE_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqStart,
  output logic              startReady,
  input  logic              reqRead,
  input  logic [15:0]       reqLen,
  input  logic [31:0]       reqPayload,
  input  logic [4:0]        reqDevIdx,
  input  logic              reqCccValid,
  input  logic [7:0]        reqCccCode,
  input  logic              reqCccBcast,
  input  logic              reqBusI2c,
  input  logic [RATE_W-1:0] reqRateHz,
  output logic              descValid,
  input  logic              descReady,
  output logic [31:0]       descWord0,
  output logic [31:0]       descWord1
);
  strobeT strobes;

  desc_enc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqStart   (reqStart),
    .descReady  (descReady),
    .startReady (startReady),
    .descValid  (descValid),
    .strobes    (strobes)
  );

  desc_enc_datapath #(.RATE_W(RATE_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .reqRead     (reqRead),
    .reqLen      (reqLen),
    .reqPayload  (reqPayload),
    .reqDevIdx   (reqDevIdx),
    .reqCccValid (reqCccValid),
    .reqCccCode  (reqCccCode),
    .reqCccBcast (reqCccBcast),
    .reqBusI2c   (reqBusI2c),
    .reqRateHz   (reqRateHz),
    .descWord0   (descWord0),
    .descWord1   (descWord1)
  );

  logic [2:0] cntField;
  assign cntField = descWord0[POS_CNT +: CNT_W];

  // R10: stalled outputs are frozen
  p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && !descReady |=> descValid && $stable(descWord0) && $stable(descWord1));
  // R11/R10: ready and valid are complementary
  p_ready_vs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    startReady != descValid);
  // R1: only the two shape codes appear
  p_shape_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |-> descWord0[2:0] <= 3'd1);
  // R2: immediate shape never flags a read and never counts past four
  p_imm_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && descWord0[2:0] == 3'd1 |-> !descWord0[POS_RD] && cntField <= 3'd4);
  // R2: lanes at or above the count are empty
  p_imm_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && descWord0[2:0] == 3'd1 && cntField < 3'd4 |->
      (descWord1 >> {cntField, 3'b000}) == 32'd0);
  // R3: a regular write is always longer than four bytes
  p_reg_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && descWord0[2:0] == 3'd0 |->
      cntField == 3'd0 && descWord1[15:0] == 16'd0 &&
      (descWord0[POS_RD] || descWord1[31:16] > 16'd4));
  // R9: unused word-0 bits stay clear
  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |-> descWord0[31:30] == 2'b00 && descWord0[22:21] == 2'b00);
  // R6/R7: mode code stays within the defined range
  p_mode_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |-> descWord0[POS_MODE +: MODE_W] <= 3'd4);
endmodule

// File: tb/tb_desc_encoder.sv
module tb_desc_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int N_CYCLES   = 6000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqStart, startReady, reqRead, reqCccValid, reqCccBcast, reqBusI2c;
  logic [15:0] reqLen;
  logic [31:0] reqPayload, reqRateHz;
  logic [4:0]  reqDevIdx;
  logic [7:0]  reqCccCode;
  logic        descValid, descReady;
  logic [31:0] descWord0, descWord1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_encoder dut (
    .clk(clk), .rst_n(rst_n), .reqStart(reqStart), .startReady(startReady),
    .reqRead(reqRead), .reqLen(reqLen), .reqPayload(reqPayload),
    .reqDevIdx(reqDevIdx), .reqCccValid(reqCccValid), .reqCccCode(reqCccCode),
    .reqCccBcast(reqCccBcast), .reqBusI2c(reqBusI2c), .reqRateHz(reqRateHz),
    .descValid(descValid), .descReady(descReady),
    .descWord0(descWord0), .descWord1(descWord1)
  );

  // reference model state
  bit          mValid;
  int          mTid;
  bit          mImm, mBcast, mI2c;
  logic [31:0] mW0, mW1;
  int          accepted = 0;

  function automatic int expMode(bit i2c, longint rate);
    if (i2c) return (rate >= 1000000) ? 1 : 0;
    if (rate > 8000000) return 0;
    if (rate > 6000000) return 1;
    if (rate > 4000000) return 2;
    if (rate > 2000000) return 3;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mValid <= 0;
      mTid   <= 0;
    end else if (mValid) begin
      if (descReady) begin
        mValid   <= 0;
        mTid     <= (mTid + 1) % 16;
        accepted <= accepted + 1;
      end
    end else if (reqStart) begin
      logic [31:0] w0, w1;
      bit imm;
      imm = !reqRead && reqLen <= 4;
      w0 = 0;
      w1 = 0;
      w0[2:0]   = imm ? 3'd1 : 3'd0;
      w0[6:3]   = 4'(mTid);
      w0[20:16] = (reqCccValid && reqCccBcast) ? 5'd0 : reqDevIdx;
      w0[28:26] = 3'(expMode(reqBusI2c, longint'(reqRateHz)));
      if (reqCccValid) begin
        w0[14:7] = reqCccCode;
        w0[15]   = 1'b1;
      end
      if (imm) begin
        w0[25:23] = reqLen[2:0];
        for (int k = 0; k < 4; k++)
          if (k < reqLen) w1[8*k +: 8] = reqPayload[8*k +: 8];
      end else begin
        w0[29]    = reqRead;
        w1[31:16] = reqLen;
      end
      mValid <= 1;
      mW0    <= w0;
      mW1    <= w1;
      mImm   <= imm;
      mBcast <= reqCccValid && reqCccBcast;
      mI2c   <= reqBusI2c;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R10 descValid", 32'(descValid), 32'(mValid));
    chk("R11 startReady", 32'(startReady), 32'(!mValid));
    if (mValid) begin
      chk("R1 shape code", 32'(descWord0[2:0]), 32'(mW0[2:0]));
      if (mImm) begin
        chk("R2 byte count", 32'(descWord0[25:23]), 32'(mW0[25:23]));
        chk("R2 payload lanes", descWord1, mW1);
        chk("R2 read bit", 32'(descWord0[29]), 32'(mW0[29]));
      end else begin
        chk("R3 length word", descWord1, mW1);
        chk("R3 read bit", 32'(descWord0[29]), 32'(mW0[29]));
        chk("R3 count field", 32'(descWord0[25:23]), 32'(mW0[25:23]));
      end
      chk("R4 tid field", 32'(descWord0[6:3]), 32'(mW0[6:3]));
      chk("R8 tid sequence", 32'(descWord0[6:3]), 32'(mTid));
      if (mBcast) chk("R5 broadcast index", 32'(descWord0[20:16]), 32'(mW0[20:16]));
      else        chk("R4 device index", 32'(descWord0[20:16]), 32'(mW0[20:16]));
      chk("R5 command fields", 32'(descWord0[15:7]), 32'(mW0[15:7]));
      if (mI2c) chk("R7 i2c mode", 32'(descWord0[28:26]), 32'(mW0[28:26]));
      else      chk("R6 i3c mode", 32'(descWord0[28:26]), 32'(mW0[28:26]));
      chk("R9 zero bits", 32'({descWord0[31:30], descWord0[22:21]}), 32'd0);
    end
  endtask

  function automatic logic [31:0] pickRate();
    int r = $urandom_range(0, 12);
    case (r)
      0: return 32'd8000001;  1: return 32'd8000000;
      2: return 32'd6000001;  3: return 32'd6000000;
      4: return 32'd4000001;  5: return 32'd4000000;
      6: return 32'd2000001;  7: return 32'd2000000;
      8: return 32'd1000000;  9: return 32'd999999;
      10: return 32'd12500000; 11: return 32'd400000;
      default: return $urandom_range(0, 15000000);
    endcase
  endfunction

  task automatic driveRandom(int cyc);
    int lsel = $urandom_range(0, 9);
    reqStart    = ($urandom_range(0, 3) != 0);
    reqRead     = $urandom_range(0, 1);
    reqLen      = (lsel < 7) ? 16'(lsel) : 16'($urandom_range(5, 65535));
    reqPayload  = $urandom;
    reqDevIdx   = 5'($urandom_range(1, 31));
    reqCccValid = ($urandom_range(0, 2) == 0);
    reqCccCode  = 8'($urandom);
    reqCccBcast = $urandom_range(0, 1);
    reqBusI2c   = ($urandom_range(0, 3) == 0);
    reqRateHz   = pickRate();
    // bursts of stalls so held descriptors get hammered with new requests
    descReady   = ((cyc / 40) % 3 == 1) ? ($urandom_range(0, 7) == 0)
                                        : ($urandom_range(0, 1) == 1);
  endtask

  initial begin
    rst_n = 0; reqStart = 0; reqRead = 0; reqLen = 0; reqPayload = 0;
    reqDevIdx = 0; reqCccValid = 0; reqCccCode = 0; reqCccBcast = 0;
    reqBusI2c = 0; reqRateHz = 0; descReady = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 32'(descValid), 32'd0);
    chk("R11 reset ready", 32'(startReady), 32'd1);
    rst_n = 1;
    @(negedge clk);
    compareAll();
    // directed: 3-byte write, broadcast command, rate exactly on a threshold
    reqStart = 1; reqRead = 0; reqLen = 3; reqPayload = 32'hA1B2C3D4;
    reqDevIdx = 5'd9; reqCccValid = 1; reqCccCode = 8'h07; reqCccBcast = 1;
    reqBusI2c = 0; reqRateHz = 32'd6000000; descReady = 0;
    @(negedge clk);
    compareAll();
    chk("R2 directed lanes", descWord1, 32'h00B2C3D4);
    // stalled: a new request must be ignored
    reqLen = 16'd300; reqRead = 1;
    @(negedge clk);
    compareAll();
    descReady = 1;
    reqStart = 0;
    @(negedge clk);
    compareAll();
    for (int c = 0; c < N_CYCLES; c++) begin
      driveRandom(c);
      @(negedge clk);
      compareAll();
    end
    checks++;
    if (accepted < 40) begin
      fails++;
      $display("FAIL R8 too few accepted descriptors for wrap: actual %0d expected >= 40", accepted);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule